// File: doc/BRIEF.md
# NAND Page ECC Checker and Corrector

This block classifies one 256-byte half of a 512-byte NAND page. It compares the 3-byte Hamming code just computed over the data with the 3-byte code read from the spare area. The comparison has four outcomes: the block is clean, one data bit is wrong and can be repaired, only the stored code is damaged, or the damage cannot be repaired. When a single data bit is wrong, the block reports the page byte offset and the bit position to invert. Data rewriting is left to the logic around it.

Each code is 24 bits wide and packed as {byte2, byte1, byte0}. Bytes 0 and 1 hold eight line-parity pairs. Pair k has its even member at bit 2k, which covers the bytes whose offset bit k is 0, and its odd member at bit 2k+1. Byte 2 holds the overall parity at bit 16 and an unused bit at bit 17 that is always zero. It also holds three column-parity pairs: the even member of pair j is at bit 18+2j and the odd member at bit 19+2j. The odd members cover the bit groups 0xAA, 0xCC and 0xF0.

A caller gives the two halves of each page one after the other, with one `chk_valid` strobe per half. The block keeps track of which half is expected next. It also keeps running counts of correctable and uncorrectable events over every block it has checked.

Top module: `nand_ecc_checker`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0 and both counters are 0. `res_valid` is 1 in exactly the cycle after each cycle in which `chk_valid` is 1, and is 0 at all other times.
- R2: The syndrome is `calc_code ^ stored_code` with bit 17 ignored. A syndrome of zero gives `res_class` = 0 (clean). This includes the case where the two codes differ only in bit 17.
- R3: When every one of the 11 parity pairs differs in exactly one member and bit 16 of the syndrome is set, the result is `res_class` = 1 (single data-bit error).
- R4: For `res_class` = 1, `res_byte[7:0]` holds the odd-member syndrome bits of line pairs 7 down to 0, which are syndrome bits 15,13,11,9,7,5,3,1. `res_bit` holds the odd-member bits of column pairs 2 down to 0, which are syndrome bits 23,21,19.
- R5: Any other syndrome with exactly one bit set gives `res_class` = 2 (error in the stored code only).
- R6: Any other nonzero syndrome gives `res_class` = 3 (uncorrectable).
- R7: The first block after reset is half 0. Each accepted block switches the half. `res_half` and `res_byte[8]` report the half of the block being reported.
- R8: `cnt_correctable` increases by one for each result of class 1 or 2. `cnt_uncorrectable` increases by one for each result of class 3. Both change in the same cycle that the result appears.
- R9: For classes 0, 2 and 3, `res_byte` and `res_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | Both codes are presented this cycle |
| calc_code | input | 24 | Code computed over the data |
| stored_code | input | 24 | Code read from the spare area |
| res_valid | output | 1 | Result strobe, one cycle after `chk_valid` |
| res_class | output | 2 | 0 clean, 1 data-bit fix, 2 code-only error, 3 uncorrectable |
| res_half | output | 1 | Half of the page the result refers to |
| res_byte | output | 9 | Page byte offset of the bit to invert |
| res_bit | output | 3 | Bit position within that byte |
| cnt_correctable | output | 16 | Count of class 1 and 2 events |
| cnt_uncorrectable | output | 16 | Count of class 3 events |

## Verification
The assertions assume that both code inputs carry known values whenever `chk_valid` is high. They also assume that a counter never has to move by more than one step per cycle, since at most one block arrives per cycle. The stimulus stays within this. The bench computes every code with its own parity generator over a 256-byte buffer, or derives it by inverting chosen code bits. It changes inputs only on the falling clock edge and holds `chk_valid` low between blocks. It checks single-bit faults at the first and last byte offsets and at several bit positions, as well as double faults and damage to the stored code alone.

// File: rtl/necc_pkg.sv
// Shared types for the NAND ECC checker.
// Assumes: the result class fits in two bits; callers decode it by value.
package necc_pkg;
    typedef enum logic [1:0] {
        BLK_CLEAN    = 2'd0,
        BLK_DATA_FIX = 2'd1,
        BLK_CODE_FIX = 2'd2,
        BLK_FAIL     = 2'd3
    } blk_class_e;
endpackage

// File: rtl/necc_syndrome.sv
// Combinational syndrome former and classifier.
// Packing: line pair k has its even member at 2k and its odd member at 2k+1.
// Overall parity is at 2*LINE_PAIRS; the bit above it is unused and masked.
// Column pair j has its even member at 2*LINE_PAIRS+2+2j and its odd member one bit higher.
// Assumes both codes are known values whenever the caller uses the outputs.
module necc_syndrome
    import necc_pkg::*;
#(
    parameter int LINE_PAIRS = 8,
    parameter int COL_PAIRS  = 3,
    localparam int CODE_W    = 2 * LINE_PAIRS + 2 + 2 * COL_PAIRS
) (
    input  logic [CODE_W-1:0]     calc_code,
    input  logic [CODE_W-1:0]     stored_code,
    output blk_class_e            blk_class,
    output logic [LINE_PAIRS-1:0] byte_off,
    output logic [COL_PAIRS-1:0]  bit_pos
);
    localparam int OVR_IDX  = 2 * LINE_PAIRS;
    localparam int SKIP_IDX = OVR_IDX + 1;
    localparam int COL_BASE = OVR_IDX + 2;
    localparam int NPAIRS   = LINE_PAIRS + COL_PAIRS;

    logic [CODE_W-1:0]     syn;
    logic [NPAIRS-1:0]     pair_split;
    logic [LINE_PAIRS-1:0] line_odd;
    logic [COL_PAIRS-1:0]  col_odd;

    // Syndrome with the unused bit removed.
    always_comb begin
        syn           = calc_code ^ stored_code;
        syn[SKIP_IDX] = 1'b0;
    end

    for (genvar k = 0; k < LINE_PAIRS; k++) begin : g_line
        assign pair_split[k] = syn[2*k] ^ syn[2*k+1];
        assign line_odd[k]   = syn[2*k+1];
    end

    for (genvar j = 0; j < COL_PAIRS; j++) begin : g_col
        assign pair_split[LINE_PAIRS+j] = syn[COL_BASE+2*j] ^ syn[COL_BASE+2*j+1];
        assign col_odd[j]               = syn[COL_BASE+2*j+1];
    end

    // Classify the syndrome and pick the location for a data fix.
    always_comb begin
        byte_off = '0;
        bit_pos  = '0;
        if (syn == '0) begin
            blk_class = BLK_CLEAN;
        end else if ((&pair_split) && syn[OVR_IDX]) begin
            blk_class = BLK_DATA_FIX;
            byte_off  = line_odd;
            bit_pos   = col_odd;
        end else if ($countones(syn) == 1) begin
            blk_class = BLK_CODE_FIX;
        end else begin
            blk_class = BLK_FAIL;
        end
    end
endmodule

// File: rtl/necc_event_counter.sv
// Event counter that increments by one when inc is high.
// Assumes at most one event per cycle; the width is sized by the caller.
module necc_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count events; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    // R8: the count moves by at most one step per cycle.
    assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/nand_ecc_checker.sv
// NAND page ECC checker: classifies each 256-byte half of a page from its
// computed and stored codes, locates single data-bit errors, tracks the page
// half and counts correctable and uncorrectable events.
// Assumes the halves arrive in order (half 0 then half 1), one strobe each.
module nand_ecc_checker
    import necc_pkg::*;
#(
    parameter int LINE_PAIRS = 8,
    parameter int COL_PAIRS  = 3,
    parameter int CNT_W      = 16,
    localparam int CODE_W    = 2 * LINE_PAIRS + 2 + 2 * COL_PAIRS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chk_valid,
    input  logic [CODE_W-1:0]     calc_code,
    input  logic [CODE_W-1:0]     stored_code,
    output logic                  res_valid,
    output logic [1:0]            res_class,
    output logic                  res_half,
    output logic [LINE_PAIRS:0]   res_byte,
    output logic [COL_PAIRS-1:0]  res_bit,
    output logic [CNT_W-1:0]      cnt_correctable,
    output logic [CNT_W-1:0]      cnt_uncorrectable
);
    localparam int SKIP_IDX = 2 * LINE_PAIRS + 1;

    blk_class_e            cls;
    logic [LINE_PAIRS-1:0] off;
    logic [COL_PAIRS-1:0]  bpos;
    logic                  half_q;
    logic                  inc_corr;
    logic                  inc_fail;

    necc_syndrome #(.LINE_PAIRS(LINE_PAIRS), .COL_PAIRS(COL_PAIRS)) u_syn (
        .calc_code   (calc_code),
        .stored_code (stored_code),
        .blk_class   (cls),
        .byte_off    (off),
        .bit_pos     (bpos)
    );

    // Track which half of the page the next block belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n)         half_q <= 1'b0;
        else if (chk_valid) half_q <= ~half_q;
    end

    // Register the result one cycle after the codes are presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_class <= 2'd0;
            res_half  <= 1'b0;
            res_byte  <= '0;
            res_bit   <= '0;
        end else begin
            res_valid <= chk_valid;
            if (chk_valid) begin
                res_class <= cls;
                res_half  <= half_q;
                res_byte  <= (cls == BLK_DATA_FIX) ? {half_q, off} : '0;
                res_bit   <= bpos;
            end
        end
    end

    // Select which event counter a block advances.
    always_comb begin
        inc_corr = chk_valid && ((cls == BLK_DATA_FIX) || (cls == BLK_CODE_FIX));
        inc_fail = chk_valid && (cls == BLK_FAIL);
    end

    necc_event_counter #(.CNT_W(CNT_W)) u_cnt_corr (
        .clk (clk), .rst_n (rst_n), .inc (inc_corr), .count (cnt_correctable)
    );

    necc_event_counter #(.CNT_W(CNT_W)) u_cnt_fail (
        .clk (clk), .rst_n (rst_n), .inc (inc_fail), .count (cnt_uncorrectable)
    );

    // R1: a result strobe follows every accepted block and nothing else.
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);

    // R2: codes that agree apart from the unused bit give a clean result.
    assert_clean_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && ((calc_code ^ stored_code) & ~(CODE_W'(1) << SKIP_IDX)) == '0)
        |=> (res_class == 2'd0));

    // R7: consecutive blocks are reported for opposite halves.
    assert_half_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && chk_valid) |=> (res_half != $past(res_half)));

    // R9: the location is zero unless the result is a data fix.
    assert_loc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class != 2'd1) |-> (res_byte == '0 && res_bit == '0));

    // R8: a class 3 result never advances the correctable count.
    assert_fail_no_corr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && cls == BLK_FAIL) |=> $stable(cnt_correctable));
endmodule

// File: tb/tb_nand_ecc_checker.sv
// Directed bench for nand_ecc_checker. Codes come from a bench-side parity
// generator over a 256-byte buffer, independent of the design.
module tb_nand_ecc_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic [23:0] calc_code = '0;
    logic [23:0] stored_code = '0;
    logic        res_valid;
    logic [1:0]  res_class;
    logic        res_half;
    logic [8:0]  res_byte;
    logic [2:0]  res_bit;
    logic [15:0] cnt_correctable;
    logic [15:0] cnt_uncorrectable;

    int checks = 0;
    int failures = 0;
    logic        exp_half = 1'b0;
    int          exp_corr = 0;
    int          exp_fail = 0;
    logic [7:0]  blk [256];

    always #2.5 clk = ~clk;

    nand_ecc_checker dut (
        .clk (clk), .rst_n (rst_n), .chk_valid (chk_valid),
        .calc_code (calc_code), .stored_code (stored_code),
        .res_valid (res_valid), .res_class (res_class), .res_half (res_half),
        .res_byte (res_byte), .res_bit (res_bit),
        .cnt_correctable (cnt_correctable), .cnt_uncorrectable (cnt_uncorrectable)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hamming code over blk, packed as in the brief.
    function automatic logic [23:0] gen_code();
        logic [23:0] c = '0;
        logic [7:0]  par = '0;
        for (int i = 0; i < 256; i++) begin
            par ^= blk[i];
            for (int k = 0; k < 8; k++) begin
                if (i[k]) c[2*k+1] ^= ^blk[i];
                else      c[2*k]   ^= ^blk[i];
            end
        end
        c[16] = ^par;
        c[18] = ^(par & 8'h55); c[19] = ^(par & 8'hAA);
        c[20] = ^(par & 8'h33); c[21] = ^(par & 8'hCC);
        c[22] = ^(par & 8'h0F); c[23] = ^(par & 8'hF0);
        return c;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 37) ^ (seed * 11) ^ (i >> 3));
    endtask

    // Present one block and check the result against the expectation.
    task automatic present(input logic [23:0] calc, input logic [23:0] stored,
                           input int ecls, input int ebyte, input int ebit, input string tag);
        @(negedge clk);
        chk_valid = 1'b1; calc_code = calc; stored_code = stored;
        @(negedge clk);
        chk_valid = 1'b0; calc_code = '0; stored_code = '0;
        if (ecls == 1 || ecls == 2) exp_corr++;
        if (ecls == 3) exp_fail++;
        check(res_valid == 1'b1, {tag, " R1 valid"}, int'(res_valid), 1);
        check(res_class == 2'(ecls), {tag, " class"}, int'(res_class), ecls);
        check(res_half == exp_half, {tag, " R7 half"}, int'(res_half), int'(exp_half));
        check(res_byte == 9'(ebyte), {tag, " R4 byte"}, int'(res_byte), ebyte);
        check(res_bit == 3'(ebit), {tag, " R4 bit"}, int'(res_bit), ebit);
        check(int'(cnt_correctable) == exp_corr, {tag, " R8 corr"}, int'(cnt_correctable), exp_corr);
        check(int'(cnt_uncorrectable) == exp_fail, {tag, " R8 fail"}, int'(cnt_uncorrectable), exp_fail);
        exp_half = ~exp_half;
        @(negedge clk);
        check(res_valid == 1'b0, {tag, " R1 strobe drop"}, int'(res_valid), 0);
    endtask

    task automatic t_reset();
        check(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);
        check(cnt_correctable == 0, "R1 reset corr", int'(cnt_correctable), 0);
        check(cnt_uncorrectable == 0, "R1 reset fail", int'(cnt_uncorrectable), 0);
    endtask

    task automatic t_clean();
        logic [23:0] c;
        fill(1); c = gen_code();
        present(c, c, 0, 0, 0, "R2 clean");
        fill(2); c = gen_code();
        present(c, c ^ 24'h020000, 0, 0, 0, "R2 masked bit17");
    endtask

    // Single data-bit error at (byte, bit): R3 class, R4 location, R9 otherwise.
    task automatic t_data(input int seed, input int by, input int bi);
        logic [23:0] good, bad;
        fill(seed); good = gen_code();
        blk[by][bi] = ~blk[by][bi];
        bad = gen_code();
        present(bad, good, 1, {exp_half, 8'(by)}, bi, "R3 data fix");
    endtask

    task automatic t_code(input int seed, input int pos);
        logic [23:0] c;
        fill(seed); c = gen_code();
        present(c, c ^ (24'd1 << pos), 2, 0, 0, "R5 code only");
    endtask

    task automatic t_double(input int seed, input int b0, input int i0, input int b1, input int i1);
        logic [23:0] good, bad;
        fill(seed); good = gen_code();
        blk[b0][i0] = ~blk[b0][i0];
        blk[b1][i1] = ~blk[b1][i1];
        bad = gen_code();
        present(bad, good, 3, 0, 0, "R6 double");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_clean();
        t_data(3, 0, 0);
        t_data(4, 255, 7);
        t_data(5, 90, 3);
        t_data(6, 130, 5);
        t_code(7, 16);
        t_code(8, 23);
        t_code(9, 4);
        t_double(10, 12, 1, 200, 6);
        t_double(11, 40, 2, 40, 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule